// File: doc/BRIEF.md
# Synchronized Zero-Stuffing Input Sampler

This block sits ahead of a digital down-converter. It raises the apparent input sample rate by inserting zero-valued words between real input samples, so the converter can run at its full clock rate on a slower source. On capture cycles it takes the word on the input bus. On every other cycle it emits zero. The spacing between captures is set by a programmable zero count N.

The capture grid is not free-running. It is anchored to a sync event, and the first capture follows that event after a fixed delay of N+3 clocks. Moving the sync pulse in time therefore picks which slot of a time-multiplexed input bus is sampled.

The sync event comes from one of four sources, chosen by a 2-bit select. The padding has a gain of 1/(N+1), and logic further down the chain must compensate for it.

Top module: `zpad_sampler`

## Requirements
- R1: After reset, `data_o` and `strobe_o` are 0. No capture happens until a sync event has been accepted.
- R2: Edge 0 is the clock edge at which a sync event is accepted. The first capture happens at edge N+3, where N is the zero count latched at that sync.
- R3: After the first capture, a capture happens every N+1 edges. This repeats until the next sync event or until enable drops.
- R4: A capture at edge k drives `data_o` with the `data_i` value sampled at edge k and drives `strobe_o` to 1, both for the cycle after edge k. On every other cycle `data_o` is 0 and `strobe_o` is 0.
- R5: With N = 0, every edge from edge 3 on is a capture, so the input passes through with one register of delay.
- R6: `sync_sel_i` chooses the sync source:
  - 0: no source.
  - 1: the first enabled cycle after `en_i` was low.
  - 2: `sync_i` low.
  - 3: `sync_i` high.
- R7: A sync event during a period restarts the grid from that edge. A sync event on a capture edge suppresses that capture.
- R8: `zero_cnt_i` is latched only at a sync event. Changing it between sync events does not alter the grid in use.
- R9: While `en_i` is low there is no capture, the outputs are 0 and sync inputs are ignored. The grid is discarded, so after `en_i` returns high no capture happens until a new sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| sync_i | input | 1 | External sync pin |
| sync_sel_i | input | 2 | Sync source select |
| zero_cnt_i | input | 4 | Zeros inserted between captures (N) |
| data_i | input | 16 | Input sample word |
| data_o | output | 16 | Zero-padded output stream |
| strobe_o | output | 1 | High for the cycle after a capture |

## Verification
The hardest case to reach is a sync event that lands exactly on a capture edge. It must suppress that capture and start a new grid. The bench reaches it by counting edges from a first sync and firing a second sync at the computed capture edge. It then checks that the strobe stays low there and that the next capture arrives N+3 edges later. A scenario table also walks every sync source, including an enable rising edge and an inverted sync pin, under several zero counts.

// File: rtl/zpad_pkg.sv
package zpad_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE   = 2'd0,
    SRC_EN_REN = 2'd1,
    SRC_PIN_LO = 2'd2,
    SRC_PIN_HI = 2'd3
  } sync_src_e;
endpackage

// File: rtl/zpad_sync_sel.sv
module zpad_sync_sel
  import zpad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sync_ev_o
);
  logic en_q;
  logic raw_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  always_comb begin
    unique case (sync_src_e'(sel_i))
      SRC_NONE:   raw_ev = 1'b0;
      SRC_EN_REN: raw_ev = ~en_q;
      SRC_PIN_LO: raw_ev = ~sync_i;
      SRC_PIN_HI: raw_ev = sync_i;
      default:    raw_ev = 1'b0;
    endcase
  end

  // sync only counts while enabled
  assign sync_ev_o = en_i & raw_ev;

  // R6
  no_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_NONE) |-> !sync_ev_o);

  // R9
  dis_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sync_ev_o);
endmodule

// File: rtl/zpad_phase_ctr.sv
module zpad_phase_ctr #(
  parameter int unsigned NZ_W    = 4,
  parameter int unsigned SYNC_LAT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sync_ev_i,
  input  logic [NZ_W-1:0] zero_cnt_i,
  output logic            cap_o
);
  localparam int unsigned CNT_W = NZ_W + 2;

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NZ_W-1:0]  nz_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign cap_o   = en_i & armed_q & ~sync_ev_i & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      nz_q    <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sync_ev_i) begin
      // first capture lands SYNC_LAT+N edges after this one
      armed_q <= 1'b1;
      cnt_q   <= CNT_W'(zero_cnt_i) + CNT_W'(SYNC_LAT - 1);
      nz_q    <= zero_cnt_i;
    end else if (armed_q) begin
      if (at_zero) cnt_q <= CNT_W'(nz_q);
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && nz_q != '0) |=> !cap_o);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ev_i |=> !cap_o);

  // R8
  nz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ev_i |=> $stable(nz_q));

  // R9
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !armed_q);
endmodule

// File: rtl/zpad_out_stage.sv
module zpad_out_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      data_o   <= cap_i ? data_i : '0;
      strobe_o <= cap_i;
    end
  end

  // R4
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> (data_o == '0));

  // R4
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (strobe_o && data_o == $past(data_i)));
endmodule

// File: rtl/zpad_sampler.sv
module zpad_sampler
  import zpad_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NZ_W     = 4,
  parameter int unsigned SYNC_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic [SEL_W-1:0]  sync_sel_i,
  input  logic [NZ_W-1:0]   zero_cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o
);
  logic sync_ev;
  logic cap;

  zpad_sync_sel u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .sync_i    (sync_i),
    .sel_i     (sync_sel_i),
    .sync_ev_o (sync_ev)
  );

  zpad_phase_ctr #(
    .NZ_W     (NZ_W),
    .SYNC_LAT (SYNC_LAT)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sync_ev_i  (sync_ev),
    .zero_cnt_i (zero_cnt_i),
    .cap_o      (cap)
  );

  zpad_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .data_i   (data_i),
    .data_o   (data_o),
    .strobe_o (strobe_o)
  );

  // R9
  dis_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !strobe_o);
endmodule

// File: tb/zpad_sampler_test.sv
module zpad_sampler_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          sync;
  logic [1:0]    sel;
  logic [3:0]    zc;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          stb;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  zpad_sampler uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .sync_i     (sync),
    .sync_sel_i (sel),
    .zero_cnt_i (zc),
    .data_i     (din),
    .data_o     (dout),
    .strobe_o   (stb)
  );

  // scenario table: {sel[5:4], nz[3:0]}
  localparam logic [5:0] SCN [8] = '{
    {2'd3, 4'd0}, {2'd3, 4'd1}, {2'd3, 4'd5}, {2'd3, 4'd15},
    {2'd2, 4'd2}, {2'd1, 4'd3}, {2'd0, 4'd4}, {2'd3, 4'd7}
  };

  function automatic bit exp_cap(int k, int n);
    return (k >= n + 3) && (((k - n - 3) % (n + 1)) == 0);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, bit ecap, logic [DW-1:0] d);
    chk(stb == ecap, req, int'(stb), int'(ecap));
    chk(dout == (ecap ? d : '0), req, int'(dout), int'(ecap ? d : '0));
  endtask

  // after a sync at edge 0, check edges 1..len against grid n
  task automatic run_window(int n, int len, string req, int base);
    for (int k = 1; k <= len; k++) begin
      din = DW'(base + k);
      tick();
      chk_out(req, exp_cap(k, n), DW'(base + k));
    end
  endtask

  task automatic fire_pin_sync(input logic [3:0] n);
    zc   = n;
    sync = 1'b1;
    din  = 16'hEEEE;
    tick();
    sync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    sync  = 1'b0;
    sel   = 2'd3;
    zc    = 4'd0;
    din   = 16'h1234;
    repeat (3) @(negedge clk);
    chk_out("R1", 1'b0, '0);
    rst_n = 1'b1;
    en    = 1'b1;
    // R1: enabled, no sync yet -> no capture
    for (int k = 0; k < 6; k++) begin
      din = DW'(16'h0100 + k);
      tick();
      chk_out("R1", 1'b0, '0);
    end

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      int n;
      logic idle;
      s    = SCN[i][5:4];
      n    = int'(SCN[i][3:0]);
      idle = (s == 2'd2);
      sel  = s;
      zc   = SCN[i][3:0];
      en   = 1'b0;
      sync = idle;
      tick();
      en   = 1'b1;
      sync = (s == 2'd3) ? 1'b1 : (s == 2'd2) ? 1'b0 : idle;
      din  = 16'hDDDD;
      tick();
      chk_out("R6", 1'b0, '0);
      sync = idle;
      for (int k = 1; k <= n + 3 + 3 * (n + 1); k++) begin
        din = DW'(16'hA000 + (i << 8) + k);
        tick();
        if (s == 2'd0)
          chk_out("R6", 1'b0, '0);
        else if (n == 0)
          chk_out("R5", exp_cap(k, n), DW'(16'hA000 + (i << 8) + k));
        else
          chk_out(k <= n + 3 ? "R2" : "R3", exp_cap(k, n),
                  DW'(16'hA000 + (i << 8) + k));
      end
    end

    // R7: resync before first capture
    sel = 2'd3;
    en  = 1'b1;
    fire_pin_sync(4'd4);
    run_window(4, 4, "R7", 16'h3000);
    fire_pin_sync(4'd4);
    run_window(4, 6, "R7", 16'h3100);
    // R7: sync on capture edge 7 suppresses that capture
    fire_pin_sync(4'd4);
    chk_out("R7", 1'b0, '0);
    run_window(4, 4 + 3 + 10, "R7", 16'h3200);

    // R8: zero count change between syncs is ignored
    fire_pin_sync(4'd2);
    zc = 4'd9;
    run_window(2, 14, "R8", 16'h4000);
    fire_pin_sync(4'd9);
    run_window(9, 9 + 3 + 20, "R8", 16'h4100);

    // R9: disable mid stream, sync while disabled, re-enable without sync
    fire_pin_sync(4'd1);
    run_window(1, 5, "R9", 16'h5000);
    en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sync = (k == 1);
      din  = DW'(16'h5100 + k);
      tick();
      chk_out("R9", 1'b0, '0);
    end
    sync = 1'b0;
    en   = 1'b1;
    for (int k = 0; k < 20; k++) begin
      din = DW'(16'h5200 + k);
      tick();
      chk_out("R9", 1'b0, '0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule